// File: doc/BRIEF.md
# Spike-Timing Plasticity Weight Updater

This block turns one synaptic weight and two spike time stamps into a new weight. The stamps record the most recent pre-synaptic spike and the most recent post-synaptic spike, taken from a free-running tick counter. Their signed gap decides the outcome. If the pre-synaptic spike came first, the weight is strengthened. If it came second, the weight is weakened. If the spikes coincide, or lie further apart than the learning window, the weight passes through unchanged. The size of a change is a peak amplitude scaled by a decaying exponential of the gap. The exponential comes from two small tables, one per direction, that are built at elaboration time.

A scheduler outside the block streams operations through it at one per clock. Each result appears a fixed two cycles after it is accepted. Peak amplitudes, decay constants, window length, weight bounds and all widths are parameters.

Top module: `stdp_wupd`

## Requirements
- R1: Let the gap be d = (post − pre) mod 2^TS_W, read as a two's-complement TS_W-bit number. If 1 ≤ d ≤ WIN, the result is min(W_MAX, w + floor(A_POS·E₊(d)/256)), where E₊(k) = round(256·exp(−k/TAU_POS)).
- R2: If −WIN ≤ d ≤ −1, the result is max(W_MIN, w − floor(A_NEG·E₋(|d|)/256)), where E₋(k) = round(256·exp(−k/TAU_NEG)).
- R3: The change is largest for a gap of one tick in each direction, and never exceeds A_POS when strengthening or A_NEG when weakening.
- R4: If |d| > WIN, including d = −2^(TS_W−1), the weight passes through unchanged.
- R5: If d = 0, the weight passes through unchanged.
- R6: Stamps wrap around. The gap is taken modulo 2^TS_W, so pre = 250, post = 3 is a gap of +9 when TS_W = 8.
- R7: A strengthened result never exceeds W_MAX. It saturates there and does not wrap.
- R8: A weakened result never falls below W_MIN. It saturates there and does not wrap.
- R9: An operation accepted in cycle c (in_valid and in_ready both high) gives out_valid high for exactly one cycle, cycle c+2. out_valid is low in every cycle that no accepted operation maps to.
- R10: From the first cycle after reset, in_ready stays high. Back-to-back operations are accepted every cycle.
- R11: While rst is high, in_ready and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block accepts an operation this cycle |
| in_weight | input | WT_W | Present synaptic weight, unsigned |
| in_pre_ts | input | TS_W | Pre-synaptic spike stamp |
| in_post_ts | input | TS_W | Post-synaptic spike stamp |
| out_valid | output | 1 | Updated weight present |
| out_weight | output | WT_W | Updated weight, unsigned |

## Verification
The direction checks in the assertions assume that every incoming weight already lies within [W_MIN, W_MAX]. They also assume that WIN is below 2^(TS_W−1), so that a gap inside the window can never be mistaken for one of the opposite sign. The bench offers only weights inside those bounds. It places the out-of-window cases at the boundaries: one tick past the window, and the half-range gap. The stream also mixes wrapped stamps with ordinary ones, so the modulo subtraction is exercised in both directions.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

  // Outcome of comparing the two spike stamps
  typedef enum logic [1:0] {
    STDP_HOLD = 2'd0,
    STDP_UP   = 2'd1,
    STDP_DOWN = 2'd2
  } stdp_dir_e;

endpackage

// File: rtl/stdp_dt_decode.sv
module stdp_dt_decode #(
  parameter int TS_W = 8,
  parameter int WIN  = 20
) (
  input  logic [TS_W-1:0]   pre_ts,
  input  logic [TS_W-1:0]   post_ts,
  output stdp_pkg::stdp_dir_e dir,
  output logic [TS_W-1:0]   mag
);
  import stdp_pkg::*;

  localparam logic [TS_W-1:0] WIN_T = TS_W'(WIN);

  // modular gap: post minus pre, wraps naturally in TS_W bits
  function automatic logic [TS_W-1:0] f_gap(input logic [TS_W-1:0] a_pre,
                                            input logic [TS_W-1:0] a_post);
    return a_post - a_pre;
  endfunction

  function automatic logic [TS_W-1:0] f_abs(input logic [TS_W-1:0] g);
    return g[TS_W-1] ? (~g + 1'b1) : g;
  endfunction

  logic [TS_W-1:0] gap;
  logic            gap_neg;

  always_comb begin
    gap     = f_gap(pre_ts, post_ts);
    gap_neg = gap[TS_W-1];
    mag     = f_abs(gap);
    if (mag == '0 || mag > WIN_T) dir = STDP_HOLD;
    else if (gap_neg)             dir = STDP_DOWN;
    else                          dir = STDP_UP;
  end

endmodule

// File: rtl/stdp_exp_rom.sv
module stdp_exp_rom #(
  parameter int WIN  = 20,
  parameter int TAU  = 8,
  parameter int FRAC = 8,
  parameter int IW   = 5
) (
  input  logic [IW-1:0] idx,
  output logic [FRAC:0] val
);

  localparam int DEPTH = 2 ** IW;
  localparam real SCALE = real'(2 ** FRAC);

  logic [FRAC:0] tbl [DEPTH];

  // one entry per tick of the window, zero beyond it
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i <= WIN) begin : g_in
      localparam int V = $rtoi(SCALE * $exp(-real'(i) / real'(TAU)) + 0.5);
      assign tbl[i] = (FRAC+1)'(V);
    end else begin : g_out
      assign tbl[i] = '0;
    end
  end

  assign val = tbl[idx];

endmodule

// File: rtl/stdp_apply.sv
module stdp_apply #(
  parameter int WT_W  = 10,
  parameter int FRAC  = 8,
  parameter int A_POS = 64,
  parameter int A_NEG = 48,
  parameter int W_MIN = 16,
  parameter int W_MAX = 1000
) (
  input  stdp_pkg::stdp_dir_e dir,
  input  logic [WT_W-1:0]   w_in,
  input  logic [FRAC:0]     factor,
  output logic [WT_W-1:0]   w_out
);
  import stdp_pkg::*;

  // scaled step: amplitude times fixed-point factor, fraction dropped
  function automatic int f_step(input int amp, input logic [FRAC:0] fac);
    return (amp * int'(fac)) >>> FRAC;
  endfunction

  function automatic int f_clamp(input int v);
    if (v > W_MAX) return W_MAX;
    if (v < W_MIN) return W_MIN;
    return v;
  endfunction

  int base;
  int res;

  always_comb begin
    base = int'(w_in);
    unique case (dir)
      STDP_UP:   res = f_clamp(base + f_step(A_POS, factor));
      STDP_DOWN: res = f_clamp(base - f_step(A_NEG, factor));
      default:   res = base;
    endcase
    w_out = WT_W'(res);
  end

endmodule

// File: rtl/stdp_wupd.sv
module stdp_wupd #(
  parameter int TS_W    = 8,
  parameter int WT_W    = 10,
  parameter int WIN     = 20,
  parameter int TAU_POS = 8,
  parameter int TAU_NEG = 10,
  parameter int A_POS   = 64,
  parameter int A_NEG   = 48,
  parameter int W_MIN   = 16,
  parameter int W_MAX   = 1000,
  parameter int FRAC    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [WT_W-1:0] in_weight,
  input  logic [TS_W-1:0] in_pre_ts,
  input  logic [TS_W-1:0] in_post_ts,
  output logic            out_valid,
  output logic [WT_W-1:0] out_weight
);
  import stdp_pkg::*;

  localparam int IW = $clog2(WIN + 1);

  // named internal events
  logic            fire;
  stdp_dir_e       dec_dir;
  logic [TS_W-1:0] dec_mag;
  logic [IW-1:0]   rom_idx;
  logic [FRAC:0]   exp_pos;
  logic [FRAC:0]   exp_neg;
  logic [FRAC:0]   sel_factor;

  logic            rdy_q;
  logic            s1_vld;
  stdp_dir_e       s1_dir;
  logic [WT_W-1:0] s1_w;
  logic [FRAC:0]   s1_fac;
  logic [WT_W-1:0] upd_w;

  assign in_ready = rdy_q;
  assign fire     = in_valid & rdy_q;

  stdp_dt_decode #(.TS_W(TS_W), .WIN(WIN)) u_dec (
    .pre_ts (in_pre_ts),
    .post_ts(in_post_ts),
    .dir    (dec_dir),
    .mag    (dec_mag)
  );

  assign rom_idx = dec_mag[IW-1:0];

  stdp_exp_rom #(.WIN(WIN), .TAU(TAU_POS), .FRAC(FRAC), .IW(IW)) u_rom_pos (
    .idx(rom_idx),
    .val(exp_pos)
  );

  stdp_exp_rom #(.WIN(WIN), .TAU(TAU_NEG), .FRAC(FRAC), .IW(IW)) u_rom_neg (
    .idx(rom_idx),
    .val(exp_neg)
  );

  assign sel_factor = (dec_dir == STDP_DOWN) ? exp_neg : exp_pos;

  // stage 1: decoded operation
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q  <= 1'b0;
      s1_vld <= 1'b0;
      s1_dir <= STDP_HOLD;
      s1_w   <= '0;
      s1_fac <= '0;
    end else begin
      rdy_q  <= 1'b1;
      s1_vld <= fire;
      if (fire) begin
        s1_dir <= dec_dir;
        s1_w   <= in_weight;
        s1_fac <= sel_factor;
      end
    end
  end

  stdp_apply #(
    .WT_W(WT_W), .FRAC(FRAC), .A_POS(A_POS), .A_NEG(A_NEG),
    .W_MIN(W_MIN), .W_MAX(W_MAX)
  ) u_apply (
    .dir   (s1_dir),
    .w_in  (s1_w),
    .factor(s1_fac),
    .w_out (upd_w)
  );

  // stage 2: result register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_weight <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) out_weight <= upd_w;
    end
  end

  // assertions
  AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready); // R10
  AST_ACCEPT_TO_S1: assert property (@(posedge clk) disable iff (rst)
    fire |=> s1_vld); // R9
  AST_S1_TO_OUT: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> out_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(s1_vld)); // R9
  AST_DIR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (fire && dec_dir != STDP_HOLD) |-> (dec_mag != '0 && int'(dec_mag) <= WIN)); // R5
  AST_HOLD_PASSES: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_dir == STDP_HOLD) |=> (out_weight == $past(s1_w))); // R4
  AST_UP_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_dir == STDP_UP && int'(s1_w) <= W_MAX)
      |=> (out_weight >= $past(s1_w))); // R1
  AST_DOWN_NEVER_RISES: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_dir == STDP_DOWN && int'(s1_w) >= W_MIN)
      |=> (out_weight <= $past(s1_w))); // R2
  AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_dir == STDP_UP)
      |=> (int'(out_weight) <= int'($past(s1_w)) + A_POS)); // R3
  AST_UPPER_SAT: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_dir != STDP_HOLD) |=> (int'(out_weight) <= W_MAX)); // R7
  AST_LOWER_SAT: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_dir != STDP_HOLD) |=> (int'(out_weight) >= W_MIN)); // R8

endmodule

// File: tb/stdp_wupd_test.sv
module stdp_wupd_test;

  localparam int TS_W = 8, WT_W = 10, WIN = 20;
  localparam int TAU_POS = 8, TAU_NEG = 10, A_POS = 64, A_NEG = 48;
  localparam int W_MIN = 16, W_MAX = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [WT_W-1:0] in_weight = '0;
  logic [TS_W-1:0] in_pre_ts = '0, in_post_ts = '0;
  logic out_valid;
  logic [WT_W-1:0] out_weight;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  stdp_wupd #(
    .TS_W(TS_W), .WT_W(WT_W), .WIN(WIN), .TAU_POS(TAU_POS), .TAU_NEG(TAU_NEG),
    .A_POS(A_POS), .A_NEG(A_NEG), .W_MIN(W_MIN), .W_MAX(W_MAX), .FRAC(8)
  ) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_weight(in_weight), .in_pre_ts(in_pre_ts), .in_post_ts(in_post_ts),
    .out_valid(out_valid), .out_weight(out_weight)
  );

  // stimulus table: weight, pre stamp, post stamp, requirement
  localparam int NV = 13;
  localparam int V_W   [NV] = '{500, 500, 500, 500, 500, 500, 500, 500, 500, 500, 990, 20, 128};
  localparam int V_PRE [NV] = '{ 10,  10,  20,  11,   0,   0,  40,  33, 250,   5,   0,  1, 128};
  localparam int V_POST[NV] = '{ 11,  15,  15,  10,  20,  21,  19,  33,   3, 250,   1,  0,   0};
  localparam int V_REQ [NV] = '{  3,   1,   2,   3,   1,   4,   4,   5,   6,   6,   7,  8,   4};

  function automatic string tag(input int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int ref_exp(input int k, input int tau);
    return $rtoi(256.0 * $exp(-real'(k) / real'(tau)) + 0.5);
  endfunction

  // expected result restated from the requirements
  function automatic int ref_weight(input int w, input int pre, input int post);
    int d;
    int r;
    d = (post - pre) & 255;
    if (d >= 128) d = d - 256;
    if (d == 0 || d > WIN || d < -WIN) return w;
    if (d > 0) begin
      r = w + (A_POS * ref_exp(d, TAU_POS)) / 256;
      return (r > W_MAX) ? W_MAX : r;
    end
    r = w - (A_NEG * ref_exp(-d, TAU_NEG)) / 256;
    return (r < W_MIN) ? W_MIN : r;
  endfunction

  task automatic chk(input string t, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // single operation; returns weight seen two cycles later
  task automatic run_one(input int w, input int pre, input int post, output int res);
    @(negedge clk);
    in_valid = 1'b1; in_weight = WT_W'(w);
    in_pre_ts = TS_W'(pre); in_post_ts = TS_W'(post);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9", "single op valid", int'(out_valid), 1);
    res = int'(out_weight);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d1, d2, res;
    // reset state, R11
    repeat (3) @(negedge clk);
    chk("R11", "in_ready in reset", int'(in_ready), 0);
    chk("R11", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "in_ready after reset", int'(in_ready), 1);
    chk("R9", "idle out_valid", int'(out_valid), 0);

    // streamed table, one per cycle: R1..R8, R10
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        chk("R9", "stream valid", int'(out_valid), 1);
        chk(tag(V_REQ[i-2]), "stream weight", int'(out_weight),
            ref_weight(V_W[i-2], V_PRE[i-2], V_POST[i-2]));
      end
      chk("R10", "ready in stream", int'(in_ready), 1);
      if (i < NV) begin
        in_valid = 1'b1;
        in_weight = WT_W'(V_W[i]);
        in_pre_ts = TS_W'(V_PRE[i]);
        in_post_ts = TS_W'(V_POST[i]);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    chk("R9", "valid drops after stream", int'(out_valid), 0);

    // latency and pulse width, R9
    in_valid = 1'b1; in_weight = 10'd300; in_pre_ts = 8'd7; in_post_ts = 8'd10;
    @(negedge clk);
    in_valid = 1'b0; in_weight = 10'd77; in_pre_ts = 8'd0; in_post_ts = 8'd1;
    chk("R9", "cycle c+1 low", int'(out_valid), 0);
    @(negedge clk);
    chk("R9", "cycle c+2 high", int'(out_valid), 1);
    chk("R1", "gap +3 weight", int'(out_weight), ref_weight(300, 7, 10));
    @(negedge clk);
    chk("R9", "cycle c+3 low", int'(out_valid), 0);
    chk("R9", "idle input ignored", int'(out_weight), ref_weight(300, 7, 10));

    // peak change at one tick, R3
    run_one(500, 0, 1, res); d1 = res - 500;
    run_one(500, 0, 2, res); d2 = res - 500;
    chk("R3", "pos peak within A_POS", int'(d1 <= A_POS && d1 > 0), 1);
    chk("R3", "pos one tick largest", int'(d1 >= d2), 1);
    run_one(500, 1, 0, res); d1 = 500 - res;
    run_one(500, 2, 0, res); d2 = 500 - res;
    chk("R3", "neg peak within A_NEG", int'(d1 <= A_NEG && d1 > 0), 1);
    chk("R3", "neg one tick largest", int'(d1 >= d2), 1);

    // window edge on the depress side, R4 and R2
    run_one(600, 20, 0, res);
    chk("R2", "gap -20", res, ref_weight(600, 20, 0));
    run_one(600, 21, 0, res);
    chk("R4", "gap -21", res, 600);

    // exact saturation points, R7 and R8
    run_one(W_MAX, 3, 4, res);
    chk("R7", "already at max", res, W_MAX);
    run_one(W_MIN, 4, 3, res);
    chk("R8", "already at min", res, W_MIN);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule